// File: doc/BRIEF.md
# DMA Transfer Pacing Controller

This block decides when a single DMA channel may take a shared bus from a CPU, and how long every bus cycle lasts. Software programs a byte count, a run/burst control register and a wait/request control register over a small register port. Each byte moves in two machine cycles: a read from the source, then a write to the destination. The block does not generate addresses. It reports who owns each cycle, whether the cycle targets I/O space, which DMA phase is active and when a cycle ends.

When both ends of the transfer are memory, no request line exists. In burst mode the channel holds the bus until the count is exhausted. In cycle-steal mode it gives the CPU one cycle slot after every byte. When either end is I/O, an external request line paces each byte and the burst bit has no effect. The request line passes through a two-flop synchroniser and is sensed either by level or by rising edge. One shared wait register stretches CPU cycles and DMA cycles alike, with one count for memory cycles and another for I/O cycles.

Top module: `dma_pacer`

## Requirements
- R1: After reset, the control register (0x30) reads 0, the count register (0x31) reads 0, the wait register (0x32) reads 0xF0, and neither own_dma nor own_cpu is high.
- R2: Register map. At 0x30, bit 0 is run and bit 1 is burst. At 0x31 is the byte count. At 0x32, bits 7:6 are the memory wait count and bits 5:4 the I/O wait count. Bit 3 is the request sense (0 = level, 1 = rising edge). Bit 2 is a stored spare sense bit. Bits 1:0 are the transfer type: bit 1 set means the source is I/O, bit 0 set means the destination is I/O. Every register reads back what was written.
- R3: Each DMA byte is one read cycle followed at once by one write cycle. Every bus cycle, DMA or CPU, lasts 1+n clocks. n is the I/O wait count if the cycle targets I/O and the memory wait count otherwise.
- R4: For a memory-to-memory transfer with burst=1 and a wait count m, DMA cycles run back to back with no CPU cycle. xfer_done is seen 2·N·(1+m)+1 clocks after the clock edge that writes run.
- R5: For a memory-to-memory transfer with burst=0, the slot after every byte's write belongs to the CPU. It is a CPU cycle if cpu_req is high, or one idle clock otherwise. The DMA then resumes.
- R6: When either end is I/O, the burst bit is ignored. In level mode a byte starts only at a cycle boundary where the synchronised request is high. A held request moves bytes back to back with no CPU cycle between them.
- R7: In edge mode, a rising request edge is latched as pending and one byte moves per edge. A request held high after its edge starts no further byte.
- R8: When the count reaches zero, the DMA releases the bus, run clears and xfer_done is high for exactly one clock.
- R9: At a cycle boundary a ready DMA byte has priority over cpu_req. A CPU cycle's target space is given by cpu_io.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| dreq | input | 1 | Asynchronous DMA request for I/O transfers |
| cpu_req | input | 1 | CPU wants a bus cycle |
| cpu_io | input | 1 | Requested CPU cycle targets I/O space |
| own_dma | output | 1 | Current bus cycle belongs to the DMA |
| own_cpu | output | 1 | Current bus cycle belongs to the CPU |
| dma_wr_phase | output | 1 | DMA cycle in progress is the write half of a byte |
| cyc_io | output | 1 | Current bus cycle targets I/O space |
| cyc_end | output | 1 | Last clock of the current bus cycle |
| xfer_done | output | 1 | One-clock pulse when the byte count is exhausted |

## Verification
The hardest situation to reach from the ports is the cycle boundary where a DMA write ends and the next slot must be decided. At that boundary the byte count, the burst bit, the request sense and cpu_req all meet at once. The bench reaches it with seeded random memory-to-memory runs that vary the byte count, wait count, burst bit and CPU demand. Each run is measured by total clocks to done, DMA clocks and CPU clocks, against closed-form expectations. Directed runs hold the request low, hold it high, and pulse it in edge mode, to show that one edge moves exactly one byte.

// File: rtl/dma_pacer.sv
module dma_pacer #(
  parameter int CNT_W = 8,
  parameter logic [7:0] ADDR_CTRL = 8'h30,
  parameter logic [7:0] ADDR_CNT  = 8'h31,
  parameter logic [7:0] ADDR_WAIT = 8'h32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       dreq,
  input  logic       cpu_req,
  input  logic       cpu_io,
  output logic       own_dma,
  output logic       own_cpu,
  output logic       dma_wr_phase,
  output logic       cyc_io,
  output logic       cyc_end,
  output logic       xfer_done
);
  logic             run, burst, sense, spare;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       memw, iow, xtype;
  logic             rq1, rq2, rq3, pend;
  logic             active, by_dma, cur_wr, cur_io, done;
  logic [1:0]       wcnt;

  wire last       = active && wcnt == 2'd0;
  wire free       = !active || last;
  wire just_wrote = last && by_dma && cur_wr;
  wire mem_only   = xtype == 2'b00;
  wire hold_off   = just_wrote && mem_only && !burst;
  wire cnt_left   = just_wrote ? (cnt != CNT_W'(1)) : (cnt != '0);
  wire go_req     = mem_only ? 1'b1 : (sense ? pend : rq2);
  wire mid_byte   = active && by_dma && !cur_wr;
  wire start_wr   = free && mid_byte;
  wire start_rd   = free && !mid_byte && run && cnt_left && go_req && !hold_off;
  wire start_cpu  = free && !mid_byte && !start_rd && cpu_req;
  wire nxt_io     = start_wr ? xtype[0] : (start_rd ? xtype[1] : cpu_io);
  wire rise       = rq2 && !rq3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {rq1, rq2, rq3, pend} <= '0;
    end else begin
      rq1 <= dreq;
      rq2 <= rq1;
      rq3 <= rq2;
      pend <= sense && ((pend && !start_rd) || rise);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      by_dma <= 1'b0;
      cur_wr <= 1'b0;
      cur_io <= 1'b0;
      wcnt   <= 2'd0;
    end else if (free) begin
      active <= start_wr || start_rd || start_cpu;
      by_dma <= start_wr || start_rd;
      cur_wr <= start_wr;
      cur_io <= nxt_io;
      wcnt   <= nxt_io ? iow : memw;
    end else begin
      wcnt <= wcnt - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      burst <= 1'b0;
      cnt   <= '0;
      {memw, iow} <= 4'hF;
      {sense, spare, xtype} <= 4'h0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (just_wrote) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          ADDR_CTRL: {burst, run} <= reg_wdata[1:0];
          ADDR_CNT:  cnt <= reg_wdata[CNT_W-1:0];
          ADDR_WAIT: {memw, iow, sense, spare, xtype} <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {6'd0, burst, run};
      ADDR_CNT:  reg_rdata = 8'(cnt);
      ADDR_WAIT: reg_rdata = {memw, iow, sense, spare, xtype};
      default:   reg_rdata = 8'd0;
    endcase
  end

  assign own_dma      = active && by_dma;
  assign own_cpu      = active && !by_dma;
  assign dma_wr_phase = own_dma && cur_wr;
  assign cyc_io       = active && cur_io;
  assign cyc_end      = last;
  assign xfer_done    = done;
endmodule

module dma_pacer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       own_dma,
  input logic       own_cpu,
  input logic       dma_wr_phase,
  input logic       cyc_io,
  input logic       cyc_end,
  input logic       xfer_done,
  input logic       run,
  input logic       burst,
  input logic [1:0] xtype,
  input logic       sense,
  input logic       pend,
  input logic       start_rd,
  input logic [1:0] memw,
  input logic [1:0] iow
);
  logic [2:0] len;
  always_ff @(posedge clk) begin
    if (!rst_n) len <= '0;
    else if (cyc_end) len <= '0;
    else if (own_dma || own_cpu) len <= len + 3'd1;
  end

  // R3
  wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> len == {1'b0, (cyc_io ? iow : memw)});
  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && own_dma && !dma_wr_phase) |=> (own_dma && dma_wr_phase));
  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && dma_wr_phase && xtype == 2'b00 && burst) |=> (own_dma || xfer_done));
  // R5
  steal_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && dma_wr_phase && xtype == 2'b00 && !burst) |=> !own_dma);
  // R7
  edge_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd && xtype != 2'b00 && sense) |-> pend);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!own_dma && !run));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
endmodule

bind dma_pacer dma_pacer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .own_dma(own_dma), .own_cpu(own_cpu),
  .dma_wr_phase(dma_wr_phase), .cyc_io(cyc_io), .cyc_end(cyc_end),
  .xfer_done(xfer_done), .run(run), .burst(burst), .xtype(xtype),
  .sense(sense), .pend(pend), .start_rd(start_rd), .memw(memw), .iow(iow)
);

// File: tb/dma_pacer_bench.sv
`timescale 1ns/1ps
module dma_pacer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, dreq = 1'b0, cpu_req = 1'b0, cpu_io = 1'b0;
  logic [7:0] reg_addr = 8'd0, reg_wdata = 8'd0, reg_rdata;
  logic own_dma, own_cpu, dma_wr_phase, cyc_io, cyc_end, xfer_done;
  int checks = 0, fails = 0;
  int unsigned ticks = 0;

  always #2.5 clk = ~clk;

  dma_pacer u_dma_pacer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .cpu_req(cpu_req), .cpu_io(cpu_io), .own_dma(own_dma), .own_cpu(own_cpu),
    .dma_wr_phase(dma_wr_phase), .cyc_io(cyc_io), .cyc_end(cyc_end),
    .xfer_done(xfer_done)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (actual %0d clocks, expected fewer)", ticks);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    cpu_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_done(int n, int m, bit b, bit c);
    int l = 1 + m;
    if (b) return 2*n*l + 1;
    if (c) return 1 + 3*l*(n-1) + 2*l;
    return 1 + (n-1)*(2*l+1) + 2*l;
  endfunction

  function automatic int exp_cpu(int n, int m, bit b, bit c);
    return (!b && c) ? (n-1)*(1+m) : 0;
  endfunction

  task automatic cpu_len(input bit io, input int exp, input string req);
    int k;
    cpu_io = io; cpu_req = 1'b1;
    do @(negedge clk); while (!cyc_end);
    k = 0;
    do begin @(negedge clk); k++; end while (!cyc_end && k < 20);
    chk(req, k, exp);
    idle(8);
  endtask

  task automatic run_mem(input int n, input int m, input bit b, input bit c);
    int k, dc, cc, v;
    idle(8);
    cpu_io = 1'b0;
    wr(8'h32, 8'(m << 6));
    wr(8'h31, 8'(n));
    wr(8'h30, {6'd0, b, 1'b1});
    cpu_req = c;
    k = 0; dc = 0; cc = 0;
    do begin
      @(negedge clk); k++;
      if (!xfer_done) begin dc += int'(own_dma); cc += int'(own_cpu); end
    end while (!xfer_done && k < 500);
    chk(b ? "R4 clocks to done (burst)" : "R5 clocks to done (steal)", k, exp_done(n, m, b, c));
    chk("R3 DMA clocks per transfer", dc, 2*n*(1+m));
    chk(b ? "R4 no CPU cycle in burst" : "R5 CPU slot per byte", cc, exp_cpu(n, m, b, c));
    @(negedge clk);
    chk("R8 done lasts one clock", int'(xfer_done), 0);
    cpu_req = 1'b0;
    rd(8'h30, v); chk("R8 run cleared at done", v & 1, 0);
    rd(8'h31, v); chk("R8 count at zero", v, 0);
  endtask

  initial begin
    int v, k, dc, ic, cc;
    bit seen;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h30, v); chk("R1 control reset", v, 0);
    rd(8'h31, v); chk("R1 count reset", v, 0);
    rd(8'h32, v); chk("R1 wait register reset", v, 8'hF0);
    chk("R1 no owner at reset", int'(own_dma | own_cpu), 0);
    cpu_len(1'b0, 4, "R3 CPU memory cycle at reset waits");
    cpu_len(1'b1, 4, "R9 CPU I/O cycle at reset waits");

    wr(8'h32, 8'hA5); rd(8'h32, v); chk("R2 wait register readback", v, 8'hA5);
    wr(8'h31, 8'h5A); rd(8'h31, v); chk("R2 count readback", v, 8'h5A);
    wr(8'h31, 8'h00);
    wr(8'h32, 8'h00);

    for (int i = 0; i < 6; i++) begin
      int mw = $urandom_range(0, 3), iw = $urandom_range(0, 3);
      idle(8);
      wr(8'h32, 8'((mw << 6) | (iw << 4)));
      cpu_len(1'b0, 1 + mw, "R3 CPU memory cycle length");
      cpu_len(1'b1, 1 + iw, "R9 CPU I/O cycle length");
    end

    run_mem(1, 0, 1'b1, 1'b1);
    run_mem(4, 3, 1'b0, 1'b1);
    run_mem(3, 1, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++)
      run_mem($urandom_range(1, 6), $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    // R6: level-sensed, memory source to I/O destination, memory wait 0, I/O wait 3
    idle(8);
    wr(8'h32, 8'h31);
    wr(8'h31, 8'd4);
    wr(8'h30, 8'h01);
    dc = 0;
    repeat (30) begin @(negedge clk); dc += int'(own_dma); end
    chk("R6 no byte while request low", dc, 0);
    rd(8'h31, v); chk("R6 count held while request low", v, 4);
    dreq = 1'b1; cpu_req = 1'b1;
    k = 0; dc = 0; ic = 0; cc = 0; seen = 0;
    do begin
      @(negedge clk); k++;
      if (!xfer_done) begin
        seen |= own_dma;
        dc += int'(own_dma);
        ic += int'(own_dma && cyc_io);
        if (seen) cc += int'(own_cpu);
      end
    end while (!xfer_done && k < 500);
    chk("R6 DMA clocks with level request", dc, 20);
    chk("R3 I/O write cycles use I/O wait", ic, 16);
    chk("R6 burst bit ignored, no CPU slot", cc, 0);
    dreq = 1'b0; idle(8);

    // R7: edge-sensed
    wr(8'h32, 8'h39);
    wr(8'h31, 8'd3);
    wr(8'h30, 8'h01);
    repeat (10) @(negedge clk);
    rd(8'h31, v); chk("R7 no byte before an edge", v, 3);
    dreq = 1'b1; dc = 0;
    repeat (40) begin @(negedge clk); dc += int'(own_dma); end
    rd(8'h31, v); chk("R7 one byte per edge", v, 2);
    chk("R7 held request moves one byte", dc, 5);
    dreq = 1'b0; repeat (5) @(negedge clk);
    dreq = 1'b1; repeat (40) @(negedge clk);
    rd(8'h31, v); chk("R7 second edge moves next byte", v, 1);
    rd(8'h30, v); chk("R7 run still set", v & 1, 1);
    dreq = 1'b0; repeat (5) @(negedge clk);
    dreq = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!xfer_done && k < 100);
    chk("R8 done after final edge", int'(xfer_done), 1);
    dreq = 1'b0;
    idle(8);
    summary();
  end
endmodule